// File: doc/BRIEF.md
# Seconds Counter with Read Snapshot

This block keeps elapsed time as a 32-bit binary count of seconds. A clock-enable input pulses at the nominal 32.768 kHz time-base rate. A 15-bit prescaler divides those pulses down to one seconds tick per 32768 enabled steps. A run control gates the time base. When it is low, both the prescaler and the count stand still.

Software reaches the count through four byte addresses, with the least significant byte at address 0. Reads never see the live count directly. They return a snapshot register, which the bus logic loads with a capture strobe. It fires that strobe on a bus START and whenever its register pointer rolls back to address 0. The bytes of a multi-byte read therefore belong to one instant while the live count keeps running.

A byte write goes straight into the matching byte of the live count. Writing address 0 also clears the prescaler. Software then has a full second to write bytes 1 to 3, in that order, before the next tick can disturb them.

Top module: `secs_counter_top`

## Requirements
- R1: With the run control high and the step enable high, the prescaler emits one single-cycle seconds tick every 2^PRE_W steps, and none otherwise.
- R2: Each seconds tick adds one to the live 32-bit count, with carries crossing byte boundaries (for example 000000FFh becomes 00000100h).
- R3: The live count wraps from FFFFFFFFh to 00000000h on a tick.
- R4: A byte write to address a (0 to 3) loads only bits [8a+7:8a] of the live count. The other three bytes keep their values.
- R5: A write to address 0 clears the prescaler. The first tick after that write comes exactly 2^PRE_W enabled steps later.
- R6: When a byte write and a tick fall in the same cycle, the written byte takes the write data. The other bytes take the incremented value.
- R7: A capture strobe copies the live count, as it stood before that clock edge, into the snapshot. The read data is the snapshot byte chosen by the address, with byte 0 as the LSB.
- R8: Without a capture strobe the snapshot holds its value while the live count advances.
- R9: With the run control low, or the step enable low, neither the prescaler nor the live count changes, and no tick is emitted.
- R10: After reset the live count, the snapshot and the prescaler are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_en_i | input | 1 | Time-base enable pulse, nominally 32.768 kHz |
| run_i | input | 1 | Oscillator run control; low freezes timekeeping |
| capture_i | input | 1 | Snapshot load strobe (bus START or pointer wrap) |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | ADDR_W (2) | Byte address, 0 = LSB |
| wdata_i | input | 8 | Byte write data |
| rdata_o | output | 8 | Snapshot byte at addr_i |
| sec_tick_o | output | 1 | One-cycle seconds tick |

## Verification
The hard cases all need a tick to land on a known cycle. These are a write and a tick in the same cycle, a carry from byte 2 into byte 3, and the wrap. At full size the bench would wait 32768 steps for each tick. It therefore builds a small prescaler of 3 bits and uses a write to address 0 to realign it to a known phase. From that point the tick cycle follows from arithmetic. The bench can then place a write to byte 3 on the exact tick edge, or capture one cycle before or after a tick.

// File: rtl/secs_pkg.sv
package secs_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/secs_prescaler.sv
module secs_prescaler #(
  parameter int unsigned PRE_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] cnt_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  // clear suppresses a tick that would coincide with it
  assign tick_o = step_i && !clear_i && (cnt_q == PRE_MAX);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/secs_live_cnt.sv
module secs_live_cnt
  import secs_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned NBYTES = CNT_W / BYTE_W;

  byte_t            bytes_q [NBYTES];
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_o + 1'b1;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic sel;
    assign sel = wr_en_i && (addr_i == ADDR_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bytes_q[b] <= '0;
      else if (sel)    bytes_q[b] <= wdata_i;
      else if (tick_i) bytes_q[b] <= cnt_inc[b*BYTE_W +: BYTE_W];
    end

    assign cnt_o[b*BYTE_W +: BYTE_W] = bytes_q[b];
  end
endmodule

// File: rtl/secs_snapshot.sv
module secs_snapshot
  import secs_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [CNT_W-1:0]  live_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CNT_W-1:0]  snap_o,
  output byte_t             rdata_o
);
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (capture_i) snap_q <= live_i;
  end

  assign snap_o  = snap_q;
  assign rdata_o = snap_q[addr_i*BYTE_W +: BYTE_W];
endmodule

// File: rtl/secs_counter_top.sv
module secs_counter_top
  import secs_pkg::*;
#(
  parameter  int unsigned CNT_W  = 32,
  parameter  int unsigned PRE_W  = 15,
  localparam int unsigned NBYTES = CNT_W / BYTE_W,
  localparam int unsigned ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic              run_i,
  input  logic              capture_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              sec_tick_o
);
  logic             step;
  logic             pre_clear;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] live_q;
  logic [CNT_W-1:0] snap_q;

  assign step      = run_i && step_en_i;
  assign pre_clear = wr_en_i && (addr_i == '0);

  secs_prescaler #(.PRE_W(PRE_W)) i_prescaler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .clear_i (pre_clear),
    .tick_o  (sec_tick_o),
    .cnt_o   (pre_q)
  );

  secs_live_cnt #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_live_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sec_tick_o),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_o   (live_q)
  );

  secs_snapshot #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_snapshot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_i),
    .live_i    (live_q),
    .addr_i    (addr_i),
    .snap_o    (snap_q),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/secs_counter_chk.sv
module secs_counter_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 15,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_en_i,
  input logic              run_i,
  input logic              capture_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              sec_tick_o,
  input logic [PRE_W-1:0]  pre_q,
  input logic [CNT_W-1:0]  live_q,
  input logic [CNT_W-1:0]  snap_q
);
  assert_no_tick_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && step_en_i) |-> !sec_tick_o);

  assert_pre_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && step_en_i) && !wr_en_i) |=> $stable(pre_q));

  assert_pre_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0) |=> pre_q == '0);

  assert_count_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && !wr_en_i) |=> live_q == $past(live_q) + 1'b1);

  assert_count_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick_o && !wr_en_i) |=> $stable(live_q));

  assert_byte_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> live_q[$past(addr_i)*8 +: 8] == $past(wdata_i));

  assert_snap_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> snap_q == $past(live_q));

  assert_snap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(snap_q));
endmodule

bind secs_counter_top secs_counter_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_en_i  (step_en_i),
  .run_i      (run_i),
  .capture_i  (capture_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .sec_tick_o (sec_tick_o),
  .pre_q      (pre_q),
  .live_q     (live_q),
  .snap_q     (snap_q)
);

// File: tb/test_secs_counter_top.sv
module test_secs_counter_top;
  localparam int PRE_W = 3;
  localparam int PERIOD = 1 << PRE_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b1;
  logic       run = 1'b1;
  logic       capture = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sec_tick;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  secs_counter_top #(.CNT_W(32), .PRE_W(PRE_W)) i_secs_counter_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .step_en_i  (step_en),
    .run_i      (run),
    .capture_i  (capture),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .sec_tick_o (sec_tick)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_count(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(2'(b), v[b*8 +: 8]);
  endtask

  task automatic snap();
    capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
  endtask

  task automatic read32(output logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      addr = 2'(b);
      #1;
      v[b*8 +: 8] = rdata;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);

    // R10 reset state
    read32(v); check("R10 snapshot after reset", v, 32'h0);
    check("R10 no tick after reset", 32'(sec_tick), 32'h0);
    snap(); read32(v); check("R10 live after reset", v, 32'h0);

    // R1 tick rate over 8 periods, with prescaler realigned
    wr(2'd0, 8'h00);
    n = 0;
    for (int i = 0; i < 8 * PERIOD; i++) begin
      if (sec_tick) n++;
      @(negedge clk);
    end
    check("R1 tick count in 8 periods", 32'(n), 32'd8);

    // R4 R7 full load and snapshot read, no tick yet
    set_count(32'h12345678);
    snap(); read32(v); check("R4 R7 load all bytes", v, 32'h12345678);

    // R5 first tick 2^PRE_W steps after the byte-0 write
    set_count(32'h0);
    n = 0;
    while (!sec_tick && n < 4 * PERIOD) begin
      @(negedge clk); n++;
    end
    check("R5 cycles to first tick after clear", 32'(n), 32'(PERIOD - 4));

    // R2 long run: capture at edge k+4+n holds floor((3+n)/8) ticks
    set_count(32'h12345678);
    wait_cyc(100);
    snap(); read32(v);
    check("R2 count after 100 cycles", v, 32'h12345678 + (103 / PERIOD));

    // R8 snapshot stable while live runs
    wait_cyc(40);
    read32(v); check("R8 snapshot holds", v, 32'h12345678 + (103 / PERIOD));
    snap(); read32(v);
    check("R7 recapture", v, 32'h12345678 + (144 / PERIOD));

    // R2 carry across bytes, for each byte boundary
    for (int b = 0; b < 3; b++) begin
      logic [31:0] base;
      base = (32'h1 << (8 * (b + 1))) - 1;
      set_count(base);
      wait_cyc(5);
      snap(); read32(v);
      check("R2 carry across byte", v, base + 1);
    end

    // R3 wrap
    set_count(32'hFFFF_FFFF);
    wait_cyc(5);
    snap(); read32(v); check("R3 wrap to zero", v, 32'h0);

    // R4 single byte write leaves others
    set_count(32'h11223344);
    wr(2'd2, 8'hEE);
    snap(); read32(v); check("R4 only byte 2 changes", v, 32'h11EE3344);

    // R6 write to byte 3 on the tick edge (posedge k+8)
    set_count(32'h00FF_FFFF);
    wait_cyc(4);
    wr(2'd3, 8'hA5);
    snap(); read32(v); check("R6 write beats increment", v, 32'hA500_0000);

    // R9 run low freezes everything
    run = 1'b0;
    set_count(32'h0000_0005);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      if (sec_tick) n++;
      @(negedge clk);
    end
    check("R9 no tick when stopped", 32'(n), 32'd0);
    snap(); read32(v); check("R9 count frozen when stopped", v, 32'h5);
    run = 1'b1;

    // R9 step enable low: prescaler holds its phase
    set_count(32'h0000_0010);
    step_en = 1'b0;
    wait_cyc(30);
    step_en = 1'b1;
    // prescaler at 3 after set_count; 5 more steps give tick at 5th edge
    wait_cyc(4);
    snap(); read32(v); check("R9 step gated, no tick yet", v, 32'h10);
    snap(); read32(v); check("R9 tick after resumed steps", v, 32'h11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule